// File: doc/BRIEF.md
# Ranked Interrupt Vector Arbiter

This block runs the address-dispatch step of an interrupt entry. When the core strobes a dispatch, the block takes a snapshot of fifteen request lines, each gated by its enable bit, and picks the one with the best rank. It turns the winner into an even low-byte offset. That offset is placed under a page byte taken from the current program counter, which gives the address of a two-byte vector in program memory.

The block then reads the two bytes through a simple synchronous read port, upper byte first, and returns the joined value as the next program counter with a one-cycle done pulse. If no request is both enabled and pending, the lowest-ranked default entry is used. A dispatch instruction at the last byte of a page takes its table from the following page.

Top module: `irq_vector_dispatch`

## Requirements
- R1: A request line counts as active only when its pending bit and its enable bit are both 1. Bit i of `irq_pend` and `irq_en` is rank i+1, where rank 1 is the highest.
- R2: Ranks 2 and 8 (bits 1 and 7) are reserved and never win, even when they are pending and enabled.
- R3: Among the active ranks the smallest rank number wins. Its table offset is 0xFE minus 2*(rank-1).
- R4: With no active rank, the default rank 16 is used, which gives offset 0xE0.
- R5: The active set and the page are taken on the clock edge where `disp_start` is accepted. Changes to the requests after that edge do not alter the vector read.
- R6: The table page (address bits 15:8) equals `pc_cur[15:8]`. When `pc_cur[7:0]` is 0xFF it is `pc_cur[15:8]+1`, wrapping modulo 256.
- R7: `tbl_rd` is high for two cycles. The first cycle presents the even table address and the second presents that address plus 1. `tbl_data` returns the byte one clock after each address.
- R8: `pc_next` becomes {byte at even address, byte at odd address}. `disp_done` is a single-cycle pulse, seen in the cycle after the fourth rising edge following the start edge.
- R9: A `disp_start` that arrives while a dispatch is in progress is ignored and starts no further memory reads.
- R10: During and after reset, `disp_done` and `tbl_rd` are 0 and `pc_next` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | 15 | Pending flags; bit i is rank i+1 |
| irq_en | input | 15 | Enable bits; bit i is rank i+1 |
| disp_start | input | 1 | Dispatch strobe, accepted when idle |
| pc_cur | input | 16 | Address of the dispatch instruction |
| tbl_addr | output | 16 | Program memory read address |
| tbl_rd | output | 1 | Program memory read strobe |
| tbl_data | input | 8 | Read data, valid one clock after the address |
| pc_next | output | 16 | Loaded service address |
| disp_done | output | 1 | One-cycle completion pulse |

## Verification
The cases hardest to reach from the ports involve timing. One is a request set that changes right after the dispatch edge. Another is a second strobe that lands in the final read cycle. The bench drives both: it flips every pending and enable bit in the cycle after the start edge, and it pulses the strobe in the last busy cycle. It then checks that the vector address and the loaded PC still follow the original snapshot and that no further read follows. Exhaustive sweeps cover every single rank, every pair of ranks, and a pseudo-random set of masks. The page rollover is covered at 0x12FF and at 0xFFFF.

// File: rtl/ivd_pkg.sv
package ivd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SAMPLE  = 3'd1,
    ST_READ_HI = 3'd2,
    ST_READ_LO = 3'd3,
    ST_LOAD    = 3'd4
  } ivd_state_e;

  // Zero-based rank index to table low byte: each step down costs two bytes.
  function automatic logic [7:0] rank_offset(input int unsigned idx);
    return 8'hFE - 8'(idx << 1);
  endfunction

endpackage

// File: rtl/ivd_req_gate.sv
module ivd_req_gate #(
  parameter int                NUM_REQ   = 15,
  parameter logic [NUM_REQ-1:0] RSVD_MASK = 15'h0082
) (
  input  logic [NUM_REQ-1:0] pend,
  input  logic [NUM_REQ-1:0] en,
  output logic [NUM_REQ-1:0] act
);

  // R1 / R2: a line is live only when enabled, pending and not reserved.
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_gate
    if (RSVD_MASK[i]) begin : g_rsvd
      assign act[i] = 1'b0;
    end else begin : g_live
      assign act[i] = pend[i] & en[i];
    end
  end

endmodule

// File: rtl/ivd_prio_enc.sv
module ivd_prio_enc import ivd_pkg::*; #(
  parameter int NUM_REQ = 15
) (
  input  logic [NUM_REQ-1:0] act,
  output logic [7:0]         offset
);

  localparam int IDX_W = $clog2(NUM_REQ + 1);

  logic             any_act;
  logic [IDX_W-1:0] win_idx;

  // R3: scan from the lowest rank upward so that the best rank is written last.
  always_comb begin
    any_act = 1'b0;
    win_idx = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (act[i]) begin
        any_act = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
    // R4: the default entry sits one rank below the last request line.
    offset = any_act ? rank_offset(int'(win_idx)) : rank_offset(NUM_REQ);
  end

endmodule

// File: rtl/ivd_fetch_seq.sv
module ivd_fetch_seq import ivd_pkg::*; #(
  parameter int NUM_REQ = 15,
  parameter int PC_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [NUM_REQ-1:0] act_in,
  input  logic [PC_W-1:0]    pc_in,
  output logic [NUM_REQ-1:0] act_snap,
  input  logic [7:0]         offset_in,
  output logic [PC_W-1:0]    mem_addr,
  output logic               mem_rd,
  input  logic [7:0]         mem_data,
  output logic [PC_W-1:0]    pc_out,
  output logic               done
);

  localparam int         PAGE_W  = PC_W - 8;
  localparam logic [7:0] DEF_OFF = rank_offset(NUM_REQ);

  ivd_state_e        st;
  logic [PAGE_W-1:0] page_r;
  logic [PC_W-1:0]   vaddr;
  logic [7:0]        hi_r;
  logic              accept;

  // R6: a dispatch at the last byte of a page uses the next page.
  function automatic logic [PAGE_W-1:0] table_page(input logic [PC_W-1:0] pc);
    return (pc[7:0] == 8'hFF) ? pc[PC_W-1:8] + PAGE_W'(1) : pc[PC_W-1:8];
  endfunction

  assign accept = (st == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      act_snap <= '0;
      page_r   <= '0;
      vaddr    <= '0;
      hi_r     <= '0;
      pc_out   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            act_snap <= act_in;
            page_r   <= table_page(pc_in);
            st       <= ST_SAMPLE;
          end
        end
        ST_SAMPLE: begin
          vaddr <= {page_r, offset_in};
          st    <= ST_READ_HI;
        end
        ST_READ_HI: st <= ST_READ_LO;
        ST_READ_LO: begin
          hi_r <= mem_data;
          st   <= ST_LOAD;
        end
        ST_LOAD: begin
          pc_out <= {hi_r, mem_data};
          done   <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd   = (st == ST_READ_HI) || (st == ST_READ_LO);
  assign mem_addr = (st == ST_READ_LO) ? {vaddr[PC_W-1:1], 1'b1} : vaddr;

  // Sampling must lead straight into the first read.
  p_sample_then_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SAMPLE) |=> (st == ST_READ_HI));

  p_snapshot_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_READ_HI) || (st == ST_READ_LO) || (st == ST_LOAD))
      |-> ($stable(act_snap) && $stable(page_r)));

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st != ST_IDLE) && start) |=> (st != ST_SAMPLE));

  p_hi_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ_HI) |-> (mem_addr[0] == 1'b0));

  p_lo_follows_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ_LO) |-> (mem_addr == $past(mem_addr) + PC_W'(1)));

  p_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ_HI) |-> (mem_addr[PC_W-1:8] == page_r));

  p_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_SAMPLE) && (act_snap == '0)) |=> (mem_addr[7:0] == DEF_OFF));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st == ST_IDLE) && !mem_rd);

endmodule

// File: rtl/irq_vector_dispatch.sv
module irq_vector_dispatch import ivd_pkg::*; #(
  parameter int                 NUM_REQ   = 15,
  parameter int                 PC_W      = 16,
  parameter logic [NUM_REQ-1:0] RSVD_MASK = 15'h0082
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] irq_pend,
  input  logic [NUM_REQ-1:0] irq_en,
  input  logic               disp_start,
  input  logic [PC_W-1:0]    pc_cur,
  output logic [PC_W-1:0]    tbl_addr,
  output logic               tbl_rd,
  input  logic [7:0]         tbl_data,
  output logic [PC_W-1:0]    pc_next,
  output logic               disp_done
);

  logic [NUM_REQ-1:0] act_live;
  logic [NUM_REQ-1:0] act_snap;
  logic [7:0]         win_offset;

  ivd_req_gate #(
    .NUM_REQ  (NUM_REQ),
    .RSVD_MASK(RSVD_MASK)
  ) u_gate (
    .pend(irq_pend),
    .en  (irq_en),
    .act (act_live)
  );

  ivd_prio_enc #(
    .NUM_REQ(NUM_REQ)
  ) u_enc (
    .act   (act_snap),
    .offset(win_offset)
  );

  ivd_fetch_seq #(
    .NUM_REQ(NUM_REQ),
    .PC_W   (PC_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (disp_start),
    .act_in   (act_live),
    .pc_in    (pc_cur),
    .act_snap (act_snap),
    .offset_in(win_offset),
    .mem_addr (tbl_addr),
    .mem_rd   (tbl_rd),
    .mem_data (tbl_data),
    .pc_out   (pc_next),
    .done     (disp_done)
  );

  // R2: reserved lines must never reach the snapshot.
  p_rsvd_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_snap & RSVD_MASK) == '0);

  // R10: nothing reads memory or completes while reset is held.
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> (!disp_done && !tbl_rd));

endmodule

// File: tb/tb_irq_vector_dispatch.sv
`timescale 1ns/1ps
module tb_irq_vector_dispatch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] irq_pend = '0;
  logic [14:0] irq_en = '0;
  logic        disp_start = 1'b0;
  logic [15:0] pc_cur = '0;
  logic [15:0] tbl_addr;
  logic        tbl_rd;
  logic [7:0]  tbl_data = '0;
  logic [15:0] pc_next;
  logic        disp_done;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_vector_dispatch dut (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
    .disp_start(disp_start), .pc_cur(pc_cur), .tbl_addr(tbl_addr),
    .tbl_rd(tbl_rd), .tbl_data(tbl_data), .pc_next(pc_next),
    .disp_done(disp_done)
  );

  // Behavioural program memory: content is a function of the address.
  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return 8'(a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (tbl_rd) tbl_data <= mem_byte(tbl_addr);

  // Expected table address: best rank, reserved 2 and 8 skipped, default 16.
  function automatic logic [15:0] exp_addr(input logic [14:0] p, input logic [14:0] e,
                                           input logic [15:0] pc);
    int rank = 16;
    logic [7:0] page;
    for (int r = 15; r >= 1; r--)
      if (r != 2 && r != 8 && p[r-1] && e[r-1]) rank = r;
    page = (pc[7:0] == 8'hFF) ? pc[15:8] + 8'd1 : pc[15:8];
    return {page, 8'hE0 + 8'(2 * (16 - rank))};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic dispatch(input logic [14:0] p, input logic [14:0] e, input logic [15:0] pc,
                          input bit perturb, input bit poke, input string req);
    logic [15:0] a = exp_addr(p, e, pc);
    logic [15:0] pcx = {mem_byte(a), mem_byte(a + 16'd1)};
    @(negedge clk);
    irq_pend = p; irq_en = e; pc_cur = pc; disp_start = 1'b1;
    @(negedge clk);
    disp_start = 1'b0;
    if (perturb) begin irq_pend = ~p; irq_en = ~e; pc_cur = ~pc; end
    @(negedge clk);
    chk(tbl_rd == 1'b1, "R7", "rd on high read", 32'(tbl_rd), 1);
    chk(tbl_addr == a, req, "high byte address", 32'(tbl_addr), 32'(a));
    @(negedge clk);
    chk(tbl_addr == a + 16'd1, "R7", "low byte address", 32'(tbl_addr), 32'(a + 16'd1));
    @(negedge clk);
    chk(disp_done == 1'b0, "R8", "done early", 32'(disp_done), 0);
    if (poke) disp_start = 1'b1;
    @(negedge clk);
    disp_start = 1'b0;
    chk(disp_done == 1'b1, "R8", "done pulse", 32'(disp_done), 1);
    chk(pc_next == pcx, "R8", "loaded pc", 32'(pc_next), 32'(pcx));
    @(negedge clk);
    chk(disp_done == 1'b0, "R8", "done width", 32'(disp_done), 0);
    if (poke) begin
      @(negedge clk);
      chk(tbl_rd == 1'b0, "R9", "busy start read", 32'(tbl_rd), 0);
      chk(disp_done == 1'b0, "R9", "busy start done", 32'(disp_done), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(disp_done == 1'b0, "R10", "reset done", 32'(disp_done), 0);
    chk(tbl_rd == 1'b0, "R10", "reset rd", 32'(tbl_rd), 0);
    chk(pc_next == 16'h0, "R10", "reset pc", 32'(pc_next), 0);
    rst_n = 1'b1;

    // R1 R2 R3: every rank alone.
    for (int i = 0; i < 15; i++)
      dispatch(15'(1 << i), 15'(1 << i), 16'(((i + 16) << 8) | 8'h34), 0, 0,
               (i == 1 || i == 7) ? "R2" : "R3");
    // R1: pending without enable, and enable without pending.
    dispatch(15'h7FFF, 15'h0000, 16'h4010, 0, 0, "R1");
    dispatch(15'h0000, 15'h7FFF, 16'h4020, 0, 0, "R1");
    dispatch(15'h5555, 15'h2AAA, 16'h4030, 0, 0, "R1");
    // R4: nothing active; R2 reserved-only also falls to default.
    dispatch(15'h0000, 15'h0000, 16'h5000, 0, 0, "R4");
    dispatch(15'h0082, 15'h0082, 16'h5100, 0, 0, "R2");
    // R3: every pair of ranks.
    for (int i = 0; i < 15; i++)
      for (int j = i + 1; j < 15; j++)
        dispatch(15'((1 << i) | (1 << j)), 15'h7FFF, 16'h6000 + 16'(i * 16 + j), 0, 0, "R3");
    // R3: pseudo-random masks.
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 60; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        dispatch(lf[14:0], {lf[7:0], lf[15:9]}, {lf[3:0], lf[15:4]}, 0, 0, "R3");
      end
    end
    // R6: page rollover and its boundaries.
    dispatch(15'h0004, 15'h0004, 16'h12FF, 0, 0, "R6");
    dispatch(15'h0004, 15'h0004, 16'hFFFF, 0, 0, "R6");
    dispatch(15'h0004, 15'h0004, 16'h12FE, 0, 0, "R6");
    dispatch(15'h0000, 15'h0000, 16'h3400, 0, 0, "R6");
    // R5: inputs flipped right after the start edge.
    dispatch(15'h0100, 15'h0100, 16'h7777, 1, 0, "R5");
    dispatch(15'h0000, 15'h0000, 16'h21FF, 1, 0, "R5");
    // R9: strobe while busy.
    dispatch(15'h0010, 15'h0010, 16'h2222, 0, 1, "R9");
    dispatch(15'h4000, 15'h4000, 16'h3333, 1, 1, "R9");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule